// File: doc/BRIEF.md
# I2C Target Event Sequencer

This block is the target side of an I2C bus, run in byte-stream mode. It holds no memory. It watches the two bus wires through synchronisers, and it answers its own 7-bit address. It turns each transaction into an ordered series of single-cycle event strobes for a local host.

On a write, the host receives every byte as it completes. On a read, the block asks the host for each byte just before it is needed. It holds SCL low until the host supplies the byte. One extra request is issued after the final byte, ahead of the controller's acknowledge. That prefetched byte is thrown away when the controller ends the read with a NACK.

A per-event mask selects which strobes are raised. Every raised strobe is also written into a small event queue, which a test environment or the host can drain in order.

Top module: `i2cev_target`

## Requirements
- R1: A START, then the own address with the write bit, then STOP, raises exactly address-match-write and then end-write. Any other address gets no ACK and raises no event.
- R2: A write of N bytes to the own address raises address-match-write, then N write-requests, then end-write. Each byte is ACKed. Each write-request is raised with its byte on `rx_data`, received MSB first.
- R3: A read of N bytes raises address-match-read, then N+1 read-requests, then end-read. The controller receives the host's bytes in the order they were accepted, MSB first. The byte fetched by the last request is discarded when the controller NACKs.
- R4: A write phase closed by a repeated START raises end-write before the address-match of the following phase. A write of one byte followed by a read of one byte gives AMW, WRQ, EWR, AMR, RRQ, RRQ, ERD.
- R5: A transmit byte is accepted only on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` rises only after a read-request. `tx_valid` presented while no request is pending has no effect on the bytes read. Each request takes exactly one byte.
- R6: When a byte must go onto the bus and none has been accepted, `scl_low_o` holds SCL low until the host supplies one. This happens only while `tx_ready` is high. A byte that arrives in time causes no stretch.
- R7: Bit i of `evt_mask` enables event i. A masked event is neither strobed nor queued. The bus handshake, the ACKs and the data carry on unchanged.
- R8: Event codes are one-hot: bit 0 address-match-read (AMR), bit 1 address-match-write (AMW), bit 2 read-request (RRQ), bit 3 write-request (WRQ), bit 4 end-read (ERD), bit 5 end-write (EWR). Each strobe lasts one cycle, and at most one bit is high in any cycle.
- R9: Raised events enter a FIFO of `EVQ_DEPTH` entries, in order. `evq_code` shows the oldest entry while `evq_empty` is low, and `evq_pop` removes it. An event that arrives when the FIFO is full is dropped. Reset leaves the FIFO empty, both bus drivers released and no strobe raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (ACK or a zero data bit) |
| evt_mask | input | 6 | Per-event enable, same bit order as the codes |
| evt_strobe | output | 6 | One-hot event strobe, one cycle wide |
| rx_data | output | 8 | Last byte received, valid with write-request |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Host offers `tx_data` |
| tx_ready | output | 1 | A read-request is waiting for a byte |
| evq_pop | input | 1 | Remove the oldest queued event |
| evq_code | output | 6 | Oldest queued event code |
| evq_empty | output | 1 | Event queue holds nothing |

## Verification
The assertions assume a well-behaved controller. SDA changes only while SCL is low, except at START and STOP. SCL and SDA never change in the same system-clock sample. Each bus phase lasts well beyond the synchroniser delay. They also assume the host never holds a byte across a read-request.

The bench's controller model keeps every half SCL period at ten system clocks. It moves one wire at a time and always waits for SCL to read high before timing its high phase, so stretching is honoured. The host model answers `tx_ready` with a single-cycle `tx_valid` after a chosen delay.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;
   localparam int BYTE_W = 8;
   localparam int EV_N   = 6;

   typedef logic [EV_N-1:0] ev_vec_t;

   // one-hot event codes; bit position is the event's identity
   localparam ev_vec_t EVC_AMR = 6'b000001;
   localparam ev_vec_t EVC_AMW = 6'b000010;
   localparam ev_vec_t EVC_RRQ = 6'b000100;
   localparam ev_vec_t EVC_WRQ = 6'b001000;
   localparam ev_vec_t EVC_ERD = 6'b010000;
   localparam ev_vec_t EVC_EWR = 6'b100000;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ACK_WAIT, ST_ACK_DRV, ST_WDATA,
      ST_RDATA, ST_RACK, ST_STALL, ST_DONE
   } eng_st_t;
endpackage

// File: rtl/i2cev_sync.sv
module i2cev_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_s;
         sda_q  <= sda_s;
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cev_engine.sv
module i2cev_engine
   import i2cev_pkg::*;
#(
   parameter logic [6:0] OWN_ADDR = 7'h43
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output ev_vec_t           ev_raw,
   output logic [BYTE_W-1:0] rx_data,
   output logic              scl_low,
   output logic              sda_low
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   eng_st_t           state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg, hold;
   logic              is_read, active, nack, need, have;
   logic              bus_evt, load_pt, avail;
   logic [BYTE_W-1:0] byte_src;

   assign bus_evt  = start_det | stop_det;
   assign tx_ready = need;
   assign avail    = have | (need & tx_valid);
   assign byte_src = have ? hold : tx_data;
   assign load_pt  = scl_fall & ~bus_evt &
                     (((state == ST_ACK_DRV) & is_read) | ((state == ST_RACK) & ~nack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         hold    <= '0;
         rx_data <= '0;
         is_read <= 1'b0;
         active  <= 1'b0;
         nack    <= 1'b0;
         need    <= 1'b0;
         have    <= 1'b0;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
         ev_raw  <= '0;
      end else begin
         ev_raw <= '0;
         if (need && tx_valid) begin
            hold <= tx_data;
            have <= 1'b1;
            need <= 1'b0;
         end
         if (bus_evt) begin
            if (active) ev_raw <= is_read ? EVC_ERD : EVC_EWR;
            active  <= 1'b0;
            need    <= 1'b0;
            have    <= 1'b0;
            sda_low <= 1'b0;
            scl_low <= 1'b0;
            cnt     <= '0;
            state   <= start_det ? ST_ADDR : ST_IDLE;
         end else begin
            unique case (state)
               ST_ADDR: if (scl_rise) begin
                  shreg <= {shreg[BYTE_W-2:0], sda_s};
                  cnt   <= cnt + CNT_W'(1);
                  if (cnt == CNT_W'(BYTE_W - 1)) begin
                     if (shreg[6:0] == OWN_ADDR) begin
                        is_read <= sda_s;
                        active  <= 1'b1;
                        ev_raw  <= sda_s ? EVC_AMR : EVC_AMW;
                        state   <= ST_ACK_WAIT;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_ACK_WAIT: if (scl_fall) begin
                  sda_low <= 1'b1;
                  state   <= ST_ACK_DRV;
                  if (is_read) begin
                     ev_raw <= EVC_RRQ;
                     need   <= 1'b1;
                  end
               end
               ST_ACK_DRV: if (scl_fall) begin
                  sda_low <= 1'b0;
                  if (!is_read) begin
                     state <= ST_WDATA;
                     cnt   <= '0;
                  end
               end
               ST_WDATA: if (scl_rise) begin
                  shreg <= {shreg[BYTE_W-2:0], sda_s};
                  cnt   <= cnt + CNT_W'(1);
                  if (cnt == CNT_W'(BYTE_W - 1)) begin
                     rx_data <= {shreg[BYTE_W-2:0], sda_s};
                     ev_raw  <= EVC_WRQ;
                     state   <= ST_ACK_WAIT;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) cnt <= cnt + CNT_W'(1);
                  if (scl_fall) begin
                     if (cnt == CNT_W'(BYTE_W)) begin
                        sda_low <= 1'b0;
                        ev_raw  <= EVC_RRQ;
                        need    <= 1'b1;
                        state   <= ST_RACK;
                     end else begin
                        sda_low <= ~shreg[BYTE_W-2];
                        shreg   <= shreg << 1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) nack <= sda_s;
                  if (scl_fall && nack) begin
                     need  <= 1'b0;
                     have  <= 1'b0;
                     state <= ST_DONE;
                  end
               end
               ST_STALL: if (need && tx_valid) begin
                  shreg   <= tx_data;
                  sda_low <= ~tx_data[BYTE_W-1];
                  have    <= 1'b0;
                  scl_low <= 1'b0;
                  cnt     <= '0;
                  state   <= ST_RDATA;
               end
               default: ;
            endcase
            if (load_pt) begin
               if (avail) begin
                  shreg   <= byte_src;
                  sda_low <= ~byte_src[BYTE_W-1];
                  have    <= 1'b0;
                  need    <= 1'b0;
                  cnt     <= '0;
                  state   <= ST_RDATA;
               end else begin
                  sda_low <= 1'b0;
                  scl_low <= 1'b1;
                  state   <= ST_STALL;
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2cev_fifo.sv
module i2cev_fifo #(
   parameter int W     = 6,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_ptr, rd_ptr;
   logic         full;

   assign empty = (wr_ptr == rd_ptr);
   assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign dout  = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push && !full) wr_ptr <= wr_ptr + 1'b1;
         if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_ptr[AW-1:0]] <= din;
   end
endmodule

// File: rtl/i2cev_target.sv
module i2cev_target
   import i2cev_pkg::*;
#(
   parameter logic [6:0] OWN_ADDR    = 7'h43,
   parameter int         SYNC_STAGES = 2,
   parameter int         EVQ_DEPTH   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_low_o,
   output logic              sda_low_o,
   input  logic [EV_N-1:0]   evt_mask,
   output logic [EV_N-1:0]   evt_strobe,
   output logic [BYTE_W-1:0] rx_data,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              evq_pop,
   output logic [EV_N-1:0]   evq_code,
   output logic              evq_empty
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (EVQ_DEPTH < 2 || (EVQ_DEPTH & (EVQ_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("EVQ_DEPTH must be a power of two, at least 2");
   end

   logic    sda_s, scl_rise, scl_fall, start_det, stop_det;
   ev_vec_t ev_raw;

   i2cev_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cev_engine #(.OWN_ADDR(OWN_ADDR)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .ev_raw    (ev_raw),
      .rx_data   (rx_data),
      .scl_low   (scl_low_o),
      .sda_low   (sda_low_o)
   );

   for (genvar g = 0; g < EV_N; g++) begin : g_mask
      assign evt_strobe[g] = ev_raw[g] & evt_mask[g];
   end

   i2cev_fifo #(.W(EV_N), .DEPTH(EVQ_DEPTH)) u_evq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (|evt_strobe),
      .din   (evt_strobe),
      .pop   (evq_pop),
      .dout  (evq_code),
      .empty (evq_empty)
   );
endmodule

// File: rtl/i2cev_checker.sv
module i2cev_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [5:0] evt_strobe,
   input logic       scl_low_o,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       evq_empty
);
   AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_strobe));                                              // R8
   AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_strobe != '0) |=> ((evt_strobe & $past(evt_strobe)) == '0));   // R8
   AST_STRETCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      scl_low_o |-> tx_ready);                                            // R6
   AST_ACCEPT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);                              // R5
   AST_QUEUE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_strobe != '0) |=> !evq_empty);                                 // R9
endmodule

bind i2cev_target i2cev_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_strobe (evt_strobe),
   .scl_low_o  (scl_low_o),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .evq_empty  (evq_empty)
);

// File: tb/i2cev_target_bench.sv
module i2cev_target_bench;
   localparam logic [6:0] ADDR = 7'h43;
   localparam int H = 10;
   localparam int QD = 8;
   localparam logic [5:0] B_AMR = 6'h01, B_AMW = 6'h02, B_RRQ = 6'h04,
                          B_WRQ = 6'h08, B_ERD = 6'h10, B_EWR = 6'h20;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n;
   logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic       scl_low_o, sda_low_o, tx_valid, tx_ready, evq_pop, evq_empty;
   logic [5:0] evt_mask, evt_strobe, evq_code;
   logic [7:0] rx_data, tx_data;
   wire        scl_bus = ~(m_scl_low | scl_low_o);
   wire        sda_bus = ~(m_sda_low | sda_low_o);

   i2cev_target u_i2cev_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .evt_mask(evt_mask),
      .evt_strobe(evt_strobe), .rx_data(rx_data), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .evq_pop(evq_pop),
      .evq_code(evq_code), .evq_empty(evq_empty)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   logic [5:0] ev_log[$], exp_q[$], prev_ev = '0;
   logic [7:0] rx_log[$], wdata[$];
   int multi_ev = 0, stretch_cycles = 0, bad_stretch = 0;
   bit host_on = 1'b0;
   int host_dly = 0, host_idx = 0;
   logic [7:0] salt = 8'h5C;

   function automatic logic [7:0] host_byte(int k);
      return 8'(k * 53) + salt;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // monitor
   initial forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
         if (evt_strobe != 0) begin
            ev_log.push_back(evt_strobe);
            if (evt_strobe[3]) rx_log.push_back(rx_data);
         end
         if ($countones(evt_strobe) > 1 || (evt_strobe & prev_ev) != 0) multi_ev++;
         prev_ev = evt_strobe;
         if (scl_low_o) stretch_cycles++;
         if (scl_low_o && !tx_ready) bad_stretch++;
      end
   end

   // host model
   initial begin
      tx_valid = 1'b0;
      tx_data  = '0;
      forever begin
         @(negedge clk);
         if (tx_ready && host_on) begin
            repeat (host_dly) @(negedge clk);
            tx_data  = host_byte(host_idx);
            tx_valid = 1'b1;
            if (tx_ready) host_idx++;
            @(negedge clk);
            tx_valid = 1'b0;
         end
      end
   end

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL all watchdog: actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic tick();
      repeat (H) @(negedge clk);
   endtask
   task automatic scl_high();
      m_scl_low = 1'b0;
      while (scl_bus !== 1'b1) @(negedge clk);
      tick();
   endtask
   task automatic scl_lo();
      m_scl_low = 1'b1;
      tick();
   endtask
   task automatic bus_start();
      m_sda_low = 1'b0; tick(); scl_high();
      m_sda_low = 1'b1; tick(); scl_lo();
   endtask
   task automatic bus_stop();
      m_sda_low = 1'b1; tick(); scl_high();
      m_sda_low = 1'b0; tick();
   endtask
   task automatic send_bit(bit b);
      m_sda_low = !b; tick(); scl_high(); scl_lo();
   endtask
   task automatic recv_bit(output bit b);
      m_sda_low = 1'b0; tick(); scl_high(); b = sda_bus; scl_lo();
   endtask
   task automatic write_byte(logic [7:0] v, output bit ack);
      bit a;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(a);
      ack = !a;
   endtask
   task automatic read_byte(output logic [7:0] v, input bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
      send_bit(!ack);
   endtask

   task automatic exp_add(logic [5:0] c);
      if ((c & evt_mask) != 0) exp_q.push_back(c);
   endtask

   task automatic clear_logs();
      ev_log.delete(); rx_log.delete(); exp_q.delete(); wdata.delete();
      stretch_cycles = 0;
   endtask

   task automatic check_events(string req);
      logic [5:0] fq[$];
      int bad = 0, n;
      repeat (4) @(negedge clk);
      chk(ev_log.size() == exp_q.size(), req, "event count", ev_log.size(), exp_q.size());
      n = (ev_log.size() < exp_q.size()) ? ev_log.size() : exp_q.size();
      for (int i = 0; i < n; i++) if (ev_log[i] != exp_q[i]) bad++;
      chk(bad == 0, req, "event order mismatches", bad, 0);
      while (!evq_empty) begin
         fq.push_back(evq_code);
         evq_pop = 1'b1;
         @(negedge clk);
         evq_pop = 1'b0;
      end
      n = (exp_q.size() < QD) ? exp_q.size() : QD;
      chk(fq.size() == n, "R9", "queued count", fq.size(), n);
      bad = 0;
      for (int i = 0; i < n && i < fq.size(); i++) if (fq[i] != exp_q[i]) bad++;
      chk(bad == 0, "R9", "queued order mismatches", bad, 0);
   endtask

   task automatic txn_write(int n, bit do_stop, string req);
      bit ack;
      logic [7:0] b;
      bus_start();
      write_byte({ADDR, 1'b0}, ack);
      chk(ack, req, "address ack", ack, 1);
      exp_add(B_AMW);
      for (int i = 0; i < n; i++) begin
         b = 8'($urandom);
         wdata.push_back(b);
         write_byte(b, ack);
         chk(ack, "R2", "data ack", ack, 1);
         exp_add(B_WRQ);
      end
      if (do_stop) begin bus_stop(); exp_add(B_EWR); end
   endtask

   task automatic txn_read(int n, string req);
      bit ack;
      logic [7:0] b;
      host_idx = 0;
      bus_start();
      write_byte({ADDR, 1'b1}, ack);
      chk(ack, req, "read address ack", ack, 1);
      exp_add(B_AMR);
      exp_add(B_RRQ);
      for (int i = 0; i < n; i++) begin
         read_byte(b, i != n - 1);
         chk(b == host_byte(i), "R3", "read byte", b, host_byte(i));
         exp_add(B_RRQ);
      end
      bus_stop();
      exp_add(B_ERD);
   endtask

   task automatic check_rx();
      int bad = 0;
      chk(rx_log.size() == wdata.size(), "R2", "rx count", rx_log.size(), wdata.size());
      for (int i = 0; i < rx_log.size() && i < wdata.size(); i++)
         if (rx_log[i] != wdata[i]) bad++;
      chk(bad == 0, "R2", "rx_data mismatches", bad, 0);
   endtask

   initial begin
      bit ack;
      int kind, n;
      void'($urandom(32'd1789));
      rst_n = 1'b0; evt_mask = 6'h3F; evq_pop = 1'b0;
      repeat (5) @(negedge clk);
      // reset state
      chk(scl_low_o == 0 && sda_low_o == 0, "R9", "bus released in reset", {scl_low_o, sda_low_o}, 0);
      chk(evt_strobe == 0, "R8", "no strobe in reset", evt_strobe, 0);
      chk(evq_empty == 1, "R9", "queue empty in reset", evq_empty, 1);
      chk(tx_ready == 0, "R5", "no request in reset", tx_ready, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      host_on = 1'b1;

      // R1 probe
      clear_logs(); txn_write(0, 1, "R1"); check_events("R1");
      // R1 other address
      clear_logs();
      bus_start(); write_byte({7'h12, 1'b0}, ack);
      chk(!ack, "R1", "foreign address nack", ack, 0);
      bus_stop(); check_events("R1");
      // R2 three bytes
      clear_logs(); txn_write(3, 1, "R2"); check_events("R2"); check_rx();
      // R3 one byte
      clear_logs(); host_dly = 1; txn_read(1, "R3"); check_events("R3");
      // R4 write then repeated start read
      clear_logs(); txn_write(1, 0, "R4"); exp_add(B_EWR); txn_read(1, "R4");
      check_events("R4"); check_rx();
      // R5 spurious tx_valid with nothing pending
      host_on = 1'b0;
      @(negedge clk); tx_data = 8'hAA; tx_valid = 1'b1;
      repeat (5) @(negedge clk);
      chk(tx_ready == 0, "R5", "ready low without request", tx_ready, 0);
      tx_valid = 1'b0; host_on = 1'b1;
      clear_logs(); host_dly = 0; txn_read(2, "R5"); check_events("R5");
      chk(stretch_cycles == 0, "R6", "no stretch when byte prompt", stretch_cycles, 0);
      // R6 slow host forces stretch
      clear_logs(); host_dly = 50; txn_read(2, "R6"); check_events("R6");
      chk(stretch_cycles > 0, "R6", "stretch seen", stretch_cycles, 1);
      // R7 masks
      evt_mask = 6'b110111;
      clear_logs(); txn_write(2, 1, "R7"); check_events("R7");
      evt_mask = 6'b000000;
      clear_logs(); host_dly = 3; txn_read(1, "R7"); check_events("R7");
      evt_mask = 6'h3F;
      // R9 overflow: 10 events, queue keeps the first 8
      clear_logs(); txn_write(8, 1, "R9"); check_events("R9"); check_rx();
      // random mix
      for (int it = 0; it < 12; it++) begin
         kind = $urandom % 3;
         n = 1 + ($urandom % 4);
         host_dly = $urandom % 30;
         salt = 8'($urandom);
         clear_logs();
         if (kind == 0) begin txn_write(n, 1, "R2"); check_events("R2"); check_rx(); end
         else if (kind == 1) begin txn_read(n, "R3"); check_events("R3"); end
         else begin
            txn_write(n, 0, "R4"); exp_add(B_EWR); txn_read(n, "R4");
            check_events("R4"); check_rx();
         end
      end
      chk(multi_ev == 0, "R8", "strobe overlap or width", multi_ev, 0);
      chk(bad_stretch == 0, "R6", "stretch without request", bad_stretch, 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule